// File: doc/BRIEF.md
# 8-to-16-bit IDE Data Bridge

This block sits between an 8-bit host data bus and the 16-bit data bus of an IDE device. It holds two byte registers: a low holding byte and a high holding byte. The host reaches the device only through the low-byte window. Reading that window latches the whole 16-bit device word at once. Writing it presents both holding bytes to the device as one word. The high-byte window never touches the device. A write to it stages the upper byte for the next low-byte write. A read from it returns the upper byte kept by the last low-byte read.

The host bus strobe `phi2_i` is sampled on `clk_i`. A capture takes place at the first clock edge at which `phi2_i` is seen high, after it was seen low at the edge before. Address, direction and data must already be stable at that edge. Address decoding and generation of the device strobes are handled elsewhere. This block receives two already-decoded active-low window selects.

Top module: `ide_byte_bridge`

## Requirements
- R1: With `lo_sel_ni`=0 and `hi_sel_ni`=1 the access targets the low-byte window. With `hi_sel_ni`=0 and `lo_sel_ni`=1 it targets the high-byte window. With both selects at 1 the bridge is idle: no register changes and both output enables stay 0.
- R2: A read of the low-byte window (`rnw_i`=1) captures `ide_rdata_i` at the capture edge. Bits 7:0 go to the low holding byte and bits 15:8 go to the high holding byte. `host_rdata_o` then returns the low holding byte.
- R3: A read of the high-byte window captures nothing from `ide_rdata_i`. `host_rdata_o` returns bits 15:8 of the word taken by the most recent low-byte read, unless a high-byte write has replaced them since.
- R4: A write of the high-byte window (`rnw_i`=0) stores `host_wdata_i` in the high holding byte and keeps `ide_oe_o` at 0.
- R5: A write of the low-byte window stores `host_wdata_i` in the low holding byte. `ide_oe_o` is then 1, with `ide_wdata_o` = {high holding byte in bits 15:8, low holding byte in bits 7:0}.
- R6: Registers load only at the capture edge. The capture edge is the first `clk_i` rising edge with `phi2_i`=1 after an edge with `phi2_i`=0. Changes to `ide_rdata_i` while `phi2_i` stays high have no effect.
- R7: Both holding bytes keep their values after an access ends. `ide_wdata_o` always shows {high, low} holding bytes, including while `ide_oe_o` is 0.
- R8: `host_oe_o` is 1 in the clock cycle after each edge that samples `phi2_i`=1 during a legal read of either window, and is 0 at all other times. `host_rdata_o` is 0 whenever `host_oe_o` is 0. `ide_oe_o` follows the same timing for low-byte writes.
- R9: While `rst_ni` is 0, both holding bytes are 0 and both output enables are 0.
- R10: A cycle with both selects at 0 is illegal and is ignored. Neither holding byte changes and neither output enable goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phi2_i | input | 1 | Host bus data strobe phase |
| rnw_i | input | 1 | 1 = host read, 0 = host write |
| lo_sel_ni | input | 1 | Active-low low-byte window select |
| hi_sel_ni | input | 1 | Active-low high-byte window select |
| host_wdata_i | input | 8 | Byte written by the host |
| host_rdata_o | output | 8 | Byte returned to the host |
| host_oe_o | output | 1 | Host data bus drive enable |
| ide_rdata_i | input | 16 | Word presented by the device |
| ide_wdata_o | output | 16 | Word driven toward the device |
| ide_oe_o | output | 1 | Device data bus drive enable |

## Verification
A wrong holding byte is visible on `ide_wdata_o` in the cycle right after the faulty capture edge, because that output always carries both bytes. A wrong enable or a wrong read multiplexer shows on `host_oe_o` or `host_rdata_o` one clock after `phi2_i` is sampled. Each bus cycle is therefore checked three times: during setup with the strobe low, during the strobe-high phase, and after the strobe falls. The device data changes in the middle of the high phase, so a design that keeps capturing during that phase is caught.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_RD_LO,
    ACC_RD_HI,
    ACC_WR_LO,
    ACC_WR_HI,
    ACC_BAD
  } acc_e;
endpackage

// File: rtl/ide_access_decode.sv
module ide_access_decode
  import ide_bridge_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_i,
  input  logic rnw_i,
  input  logic lo_sel_ni,
  input  logic hi_sel_ni,
  output acc_e acc_o,
  output logic strobe_o
);
  logic phi2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi2_q <= 1'b0;
    else         phi2_q <= phi2_i;
  end

  assign strobe_o = phi2_i & ~phi2_q;

  always_comb begin
    unique case ({lo_sel_ni, hi_sel_ni})
      2'b11:   acc_o = ACC_IDLE;
      2'b01:   acc_o = rnw_i ? ACC_RD_LO : ACC_WR_LO;
      2'b10:   acc_o = rnw_i ? ACC_RD_HI : ACC_WR_HI;
      default: acc_o = ACC_BAD;
    endcase
  end

  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/ide_hold_regs.sv
module ide_hold_regs
  import ide_bridge_pkg::*;
#(
  parameter int HOST_W = 8,
  localparam int IDE_W = 2 * HOST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  acc_e              acc_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  input  logic [IDE_W-1:0]  ide_rdata_i,
  output logic [HOST_W-1:0] lo_o,
  output logic [HOST_W-1:0] hi_o
);
  logic [HOST_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (strobe_i) begin
      unique case (acc_i)
        ACC_RD_LO: begin
          lo_q <= ide_rdata_i[HOST_W-1:0];
          hi_q <= ide_rdata_i[IDE_W-1:HOST_W];
        end
        ACC_WR_LO: lo_q <= host_wdata_i;
        ACC_WR_HI: hi_q <= host_wdata_i;
        default:   ;
      endcase
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R2
  lo_read_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && acc_i == ACC_RD_LO) |=> lo_q == $past(ide_rdata_i[HOST_W-1:0]));
  // R3
  hi_read_no_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && acc_i == ACC_RD_HI) |=> ($stable(hi_q) && $stable(lo_q)));
  // R4
  hi_write_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && acc_i == ACC_WR_HI) |=> $stable(lo_q));
  // R10
  illegal_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_BAD) |=> ($stable(lo_q) && $stable(hi_q)));
  // R6
  no_strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/ide_drive_ctrl.sv
module ide_drive_ctrl
  import ide_bridge_pkg::*;
#(
  parameter int HOST_W = 8,
  localparam int IDE_W = 2 * HOST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  acc_e              acc_i,
  input  logic [HOST_W-1:0] lo_i,
  input  logic [HOST_W-1:0] hi_i,
  output logic [HOST_W-1:0] host_rdata_o,
  output logic              host_oe_o,
  output logic [IDE_W-1:0]  ide_wdata_o,
  output logic              ide_oe_o
);
  logic host_oe_q, ide_oe_q, rd_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_oe_q <= 1'b0;
      ide_oe_q  <= 1'b0;
      rd_hi_q   <= 1'b0;
    end else begin
      host_oe_q <= phi2_i && (acc_i == ACC_RD_LO || acc_i == ACC_RD_HI);
      ide_oe_q  <= phi2_i && (acc_i == ACC_WR_LO);
      if (phi2_i) rd_hi_q <= (acc_i == ACC_RD_HI);
    end
  end

  assign host_oe_o    = host_oe_q;
  assign ide_oe_o     = ide_oe_q;
  assign host_rdata_o = host_oe_q ? (rd_hi_q ? hi_i : lo_i) : '0;
  assign ide_wdata_o  = {hi_i, lo_i};

  // R8
  oe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_oe_q && ide_oe_q));
  // R8
  host_oe_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phi2_i |=> !host_oe_q);
  // R10
  bad_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_BAD) |=> (!host_oe_q && !ide_oe_q));
endmodule

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge
  import ide_bridge_pkg::*;
#(
  parameter int HOST_W = 8,
  localparam int IDE_W = 2 * HOST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic              rnw_i,
  input  logic              lo_sel_ni,
  input  logic              hi_sel_ni,
  input  logic [HOST_W-1:0] host_wdata_i,
  output logic [HOST_W-1:0] host_rdata_o,
  output logic              host_oe_o,
  input  logic [IDE_W-1:0]  ide_rdata_i,
  output logic [IDE_W-1:0]  ide_wdata_o,
  output logic              ide_oe_o
);
  acc_e              acc;
  logic              strobe;
  logic [HOST_W-1:0] lo_q, hi_q;

  ide_access_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phi2_i   (phi2_i),
    .rnw_i    (rnw_i),
    .lo_sel_ni(lo_sel_ni),
    .hi_sel_ni(hi_sel_ni),
    .acc_o    (acc),
    .strobe_o (strobe)
  );

  ide_hold_regs #(.HOST_W(HOST_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .acc_i       (acc),
    .host_wdata_i(host_wdata_i),
    .ide_rdata_i (ide_rdata_i),
    .lo_o        (lo_q),
    .hi_o        (hi_q)
  );

  ide_drive_ctrl #(.HOST_W(HOST_W)) u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phi2_i      (phi2_i),
    .acc_i       (acc),
    .lo_i        (lo_q),
    .hi_i        (hi_q),
    .host_rdata_o(host_rdata_o),
    .host_oe_o   (host_oe_o),
    .ide_wdata_o (ide_wdata_o),
    .ide_oe_o    (ide_oe_o)
  );

  // R1
  idle_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_sel_ni && hi_sel_ni) |=> (!host_oe_o && !ide_oe_o));
  // R4
  hi_write_no_ide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_sel_ni && lo_sel_ni && !rnw_i) |=> !ide_oe_o);
  // R5
  lo_write_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !lo_sel_ni && hi_sel_ni && !rnw_i)
      |=> (ide_oe_o && ide_wdata_o[HOST_W-1:0] == $past(host_wdata_i)));
endmodule

// File: tb/tb_ide_byte_bridge.sv
module tb_ide_byte_bridge;
  typedef struct {
    string       req;
    logic [7:0]  hd;
    logic        hoe;
    logic [15:0] iw;
    logic        ioe;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0, rnw = 1'b1, lo_n = 1'b1, hi_n = 1'b1;
  logic [7:0]  wd = '0;
  logic [15:0] ide = '0;
  logic [7:0]  hd;
  logic        hoe, ioe;
  logic [15:0] iw;

  logic [7:0]  m_lo = '0, m_hi = '0;
  exp_t        q[$];
  event        chk_ev;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ide_byte_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .phi2_i(phi2), .rnw_i(rnw),
    .lo_sel_ni(lo_n), .hi_sel_ni(hi_n), .host_wdata_i(wd),
    .host_rdata_o(hd), .host_oe_o(hoe), .ide_rdata_i(ide),
    .ide_wdata_o(iw), .ide_oe_o(ioe)
  );

  // monitor: pops expected items and compares with the ports
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (hd !== e.hd || hoe !== e.hoe || iw !== e.iw || ioe !== e.ioe) begin
        errors++;
        $display("FAIL %s: got hd=%h hoe=%b iw=%h ioe=%b exp hd=%h hoe=%b iw=%h ioe=%b",
                 e.req, hd, hoe, iw, ioe, e.hd, e.hoe, e.iw, e.ioe);
      end
    end
  end

  task automatic expect_now(string req, logic [7:0] h, logic ho, logic [15:0] w, logic wo);
    exp_t e;
    e.req = req; e.hd = h; e.hoe = ho; e.iw = w; e.ioe = wo;
    q.push_back(e);
    ->chk_ev;
  endtask

  // one host bus cycle; ide_mid replaces device data during the strobe-high phase
  task automatic bus(string req, logic r, logic ln, logic hn, logic [7:0] d,
                     logic [15:0] dv, logic [15:0] ide_mid);
    logic legal, e_hoe, e_ioe;
    logic [7:0] e_hd;
    legal = ln ^ hn;
    rnw = r; lo_n = ln; hi_n = hn; wd = d; ide = dv; phi2 = 1'b0;
    @(negedge clk);
    expect_now("R8", 8'h00, 1'b0, {m_hi, m_lo}, 1'b0);
    if (legal) begin
      if (r && !ln) begin m_lo = dv[7:0]; m_hi = dv[15:8]; end
      if (!r && !hn) m_hi = d;
      if (!r && !ln) m_lo = d;
    end
    e_hoe = legal && r;
    e_ioe = legal && !r && !ln;
    e_hd  = e_hoe ? (!hn ? m_hi : m_lo) : 8'h00;
    phi2 = 1'b1;
    @(negedge clk);
    ide = ide_mid;
    @(negedge clk);
    expect_now(req, e_hd, e_hoe, {m_hi, m_lo}, e_ioe);
    phi2 = 1'b0;
    @(negedge clk);
    expect_now("R7", 8'h00, 1'b0, {m_hi, m_lo}, 1'b0);
    lo_n = 1'b1; hi_n = 1'b1; rnw = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R9", 8'h00, 1'b0, 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    bus("R4", 1'b0, 1'b1, 1'b0, 8'hA5, 16'h0000, 16'h0000);
    bus("R3", 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000, 16'h0000);
    bus("R5", 1'b0, 1'b0, 1'b1, 8'h3C, 16'h0000, 16'h0000);
    bus("R2", 1'b1, 1'b0, 1'b1, 8'h00, 16'h1234, 16'h1234);
    bus("R3", 1'b1, 1'b1, 1'b0, 8'h00, 16'hFFFF, 16'hFFFF);
    bus("R5", 1'b0, 1'b0, 1'b1, 8'h77, 16'h0000, 16'h0000);
    bus("R10", 1'b0, 1'b0, 1'b0, 8'h99, 16'h0000, 16'h0000);
    bus("R10", 1'b1, 1'b0, 1'b0, 8'h00, 16'h5555, 16'h5555);
    bus("R1", 1'b1, 1'b1, 1'b1, 8'h00, 16'hAAAA, 16'hAAAA);
    bus("R1", 1'b0, 1'b1, 1'b1, 8'h42, 16'h0000, 16'h0000);
    bus("R6", 1'b1, 1'b0, 1'b1, 8'h00, 16'hBEEF, 16'h0000);
    bus("R3", 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000, 16'h0000);
    bus("R4", 1'b0, 1'b1, 1'b0, 8'h5A, 16'h0000, 16'h0000);
    bus("R5", 1'b0, 1'b0, 1'b1, 8'hC3, 16'h0000, 16'h0000);
    rst_n = 1'b0;
    m_lo = '0; m_hi = '0;
    @(negedge clk);
    expect_now("R9", 8'h00, 1'b0, 16'h0000, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule